// File: doc/BRIEF.md
# DPLL Mode and Frequency-Offset Controller

This block steers the increment of a phase-accumulator NCO inside a digital PLL. Its output clock enable is the carry-out of that accumulator. A mode input selects between freerun and locked operation. In freerun the increment comes from a programmed centre value. In locked operation it comes from an external loop increment, which stands in for the loop filter.

When software steering is enabled in freerun, the increment is moved to the centre value plus a signed offset word, and the sum saturates at the increment bounds. A control bit chooses how the increment moves. It either jumps to the new value on the next cycle, or it is ramped by a slew limiter that changes it by at most a programmed step on each update tick. The ramp stops exactly on the target.

An internal reset mode holds the NCO and the slew state in reset and stops the output. The registers keep their values in this mode and remain accessible. A status bit flags the forbidden combination of freerun with a fast-lock request.

Top module: `dpll_freq_ctrl`

## Requirements
- R1: On `rst`, the registers read back as follows: control is 0, centre is `CENTRE_DEF`, offset is 0 and step is `STEP_DEF`. `active_inc` equals `CENTRE_DEF` and `clk_en` is 0.
- R2: Registers are written through `wr_en`/`wr_addr`/`wr_data` and read combinationally through `rd_addr`/`rd_data`. The addresses are 0 = control (8 bits, zero-extended on read), 1 = centre, 2 = signed 16-bit offset (sign-extended on read) and 3 = slew step.
- R3: In freerun (`mode_locked`=0) with control bit 3 clear, `active_inc` takes the centre value one cycle after the centre register changes. The offset word has no effect, whatever the value of bit 4.
- R4: With `mode_locked`=1, `active_inc` equals `loop_inc` from the previous cycle. The offset word and control bits 3 and 4 have no effect.
- R5: In freerun with control bits 3 and 4 both set, `active_inc` equals centre plus the sign-extended offset on the cycle after the offset is written.
- R6: The centre-plus-offset sum saturates: below zero it gives 0, and above 2^32-1 it gives 32'hFFFFFFFF.
- R7: In freerun with bit 3 set and bit 4 clear, `active_inc` changes only on cycles where `tick` is high. Each change is by at most the step value, and the value never passes the target; the last step lands exactly on it.
- R8: `on_target` is 1 exactly when `active_inc` equals the current target increment.
- R9: While control bit 0 is set, `clk_en` is 0 and `active_inc` is held at the centre value. All registers remain writable and readable, and their values are unchanged by entering or leaving this mode.
- R10: `clk_en` is the carry-out of a 32-bit phase accumulator. With increment 2^31 it is high in 4 of any 8 consecutive cycles, and with increment 2^30 it is high in 4 of any 16 consecutive cycles.
- R11: `cfg_err` is 1 exactly when `mode_locked` is 0 and control bit 5 (fast-lock request) is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data |
| mode_locked | input | 1 | 1 = locked operation, 0 = freerun |
| loop_inc | input | 32 | Increment supplied by the loop in locked operation |
| tick | input | 1 | Slew limiter update tick |
| clk_en | output | 1 | Output clock enable (accumulator carry) |
| active_inc | output | 32 | Increment currently applied to the NCO |
| on_target | output | 1 | Active increment equals target |
| cfg_err | output | 1 | Freerun combined with fast-lock request |

## Verification
The assertions check four rules on every cycle. The increment holds between ticks while ramping. A ramp step never passes the target. Outside ramp mode the increment follows the target and, when locked, the loop increment. The output enable stays low in internal reset. Only the bench scenarios can show the rest: the saturated sums, the exact ramp sequence and where it stops, the preserved register values across internal reset, and the carry rate of the accumulator for given increments.

// File: rtl/dfc_pkg.sv
package dfc_pkg;
    localparam int ADDR_W    = 2;
    localparam int CTL_W     = 8;
    localparam logic [ADDR_W-1:0] A_CTL    = 2'd0;
    localparam logic [ADDR_W-1:0] A_CENTRE = 2'd1;
    localparam logic [ADDR_W-1:0] A_OFFS   = 2'd2;
    localparam logic [ADDR_W-1:0] A_STEP   = 2'd3;

    localparam int B_HALT  = 0;
    localparam int B_SWEN  = 3;
    localparam int B_JUMP  = 4;
    localparam int B_FAST  = 5;

    typedef struct packed {
        logic fast_req;
        logic jump;
        logic sw_en;
        logic halt;
    } ctl_t;

    typedef enum logic [1:0] {
        SRC_CENTRE,
        SRC_OFFSET,
        SRC_LOOP
    } src_e;

    function automatic ctl_t decode_ctl(input logic [CTL_W-1:0] raw);
        ctl_t c;
        c.fast_req = raw[B_FAST];
        c.jump     = raw[B_JUMP];
        c.sw_en    = raw[B_SWEN];
        c.halt     = raw[B_HALT];
        return c;
    endfunction
endpackage

// File: rtl/dfc_regs.sv
module dfc_regs
    import dfc_pkg::*;
#(
    parameter int INC_W = 32,
    parameter int OFS_W = 16,
    parameter logic [INC_W-1:0] CENTRE_DEF = '0,
    parameter logic [INC_W-1:0] STEP_DEF = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [INC_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [INC_W-1:0]  rd_data,
    output ctl_t              ctl,
    output logic [INC_W-1:0]  centre,
    output logic [OFS_W-1:0]  offs,
    output logic [INC_W-1:0]  step
);
    logic [CTL_W-1:0] ctl_q;
    logic [INC_W-1:0] centre_q;
    logic [OFS_W-1:0] offs_q;
    logic [INC_W-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= '0;
            centre_q <= CENTRE_DEF;
            offs_q   <= '0;
            step_q   <= STEP_DEF;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTL:    ctl_q    <= wr_data[CTL_W-1:0];
                A_CENTRE: centre_q <= wr_data;
                A_OFFS:   offs_q   <= wr_data[OFS_W-1:0];
                default:  step_q   <= wr_data;
            endcase
        end
    end

    always_comb begin
        case (rd_addr)
            A_CTL:    rd_data = {{(INC_W-CTL_W){1'b0}}, ctl_q};
            A_CENTRE: rd_data = centre_q;
            A_OFFS:   rd_data = {{(INC_W-OFS_W){offs_q[OFS_W-1]}}, offs_q};
            default:  rd_data = step_q;
        endcase
    end

    assign ctl    = decode_ctl(ctl_q);
    assign centre = centre_q;
    assign offs   = offs_q;
    assign step   = step_q;
endmodule

// File: rtl/dfc_target.sv
module dfc_target
    import dfc_pkg::*;
#(
    parameter int INC_W = 32,
    parameter int OFS_W = 16
) (
    input  ctl_t             ctl,
    input  logic             locked,
    input  logic [INC_W-1:0] centre,
    input  logic [OFS_W-1:0] offs,
    input  logic [INC_W-1:0] loop_inc,
    output logic [INC_W-1:0] target,
    output logic             ramp_mode
);
    localparam int SUM_W = INC_W + 2;

    src_e                     src;
    logic signed [SUM_W-1:0]  sum;
    logic [INC_W-1:0]         sat_sum;

    always_comb begin
        if (locked)          src = SRC_LOOP;
        else if (ctl.sw_en)  src = SRC_OFFSET;
        else                 src = SRC_CENTRE;
    end

    assign sum = $signed({2'b00, centre})
               + $signed({{(SUM_W-OFS_W){offs[OFS_W-1]}}, offs});

    always_comb begin
        if (sum[SUM_W-1])       sat_sum = '0;
        else if (sum[SUM_W-2])  sat_sum = '1;
        else                    sat_sum = sum[INC_W-1:0];
    end

    always_comb begin
        case (src)
            SRC_LOOP:   target = loop_inc;
            SRC_OFFSET: target = sat_sum;
            default:    target = centre;
        endcase
    end

    assign ramp_mode = (src == SRC_OFFSET) && !ctl.jump;
endmodule

// File: rtl/dfc_slew.sv
module dfc_slew #(
    parameter int INC_W = 32,
    parameter logic [INC_W-1:0] CENTRE_DEF = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             halt,
    input  logic             ramp_mode,
    input  logic             tick,
    input  logic [INC_W-1:0] target,
    input  logic [INC_W-1:0] centre,
    input  logic [INC_W-1:0] step,
    output logic [INC_W-1:0] active
);
    logic [INC_W-1:0] act_q;
    logic [INC_W-1:0] stepped;
    logic [INC_W-1:0] gap;

    always_comb begin
        if (target >= act_q) begin
            gap     = target - act_q;
            stepped = (gap <= step) ? target : act_q + step;
        end else begin
            gap     = act_q - target;
            stepped = (gap <= step) ? target : act_q - step;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            act_q <= CENTRE_DEF;
        else if (halt)      act_q <= centre;
        else if (!ramp_mode) act_q <= target;
        else if (tick)      act_q <= stepped;
    end

    assign active = act_q;

    // R7
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
        (ramp_mode && !tick && !halt) |=> $stable(act_q));
    // R7
    no_overshoot_up_chk: assert property (@(posedge clk) disable iff (rst)
        (ramp_mode && tick && !halt && act_q <= target) |=> (act_q <= $past(target)));
    // R7
    no_overshoot_dn_chk: assert property (@(posedge clk) disable iff (rst)
        (ramp_mode && tick && !halt && act_q >= target) |=> (act_q >= $past(target)));
    // R3
    follow_target_chk: assert property (@(posedge clk) disable iff (rst)
        (!ramp_mode && !halt) |=> (act_q == $past(target)));
endmodule

// File: rtl/dfc_nco.sv
module dfc_nco #(
    parameter int INC_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             halt,
    input  logic [INC_W-1:0] inc,
    output logic             clk_en
);
    logic [INC_W-1:0] phase_q;
    logic [INC_W:0]   nxt;
    logic             en_q;

    assign nxt = {1'b0, phase_q} + {1'b0, inc};

    always_ff @(posedge clk) begin
        if (rst || halt) begin
            phase_q <= '0;
            en_q    <= 1'b0;
        end else begin
            phase_q <= nxt[INC_W-1:0];
            en_q    <= nxt[INC_W];
        end
    end

    assign clk_en = en_q;

    // R9
    quiet_in_halt_chk: assert property (@(posedge clk) disable iff (rst)
        halt |=> !clk_en);
endmodule

// File: rtl/dpll_freq_ctrl.sv
module dpll_freq_ctrl
    import dfc_pkg::*;
#(
    parameter int INC_W = 32,
    parameter int OFS_W = 16,
    parameter logic [INC_W-1:0] CENTRE_DEF = 32'h0100_0000,
    parameter logic [INC_W-1:0] STEP_DEF = 32'd16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [INC_W-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [INC_W-1:0] rd_data,
    input  logic             mode_locked,
    input  logic [INC_W-1:0] loop_inc,
    input  logic             tick,
    output logic             clk_en,
    output logic [INC_W-1:0] active_inc,
    output logic             on_target,
    output logic             cfg_err
);
    ctl_t             ctl;
    logic [INC_W-1:0] centre;
    logic [OFS_W-1:0] offs;
    logic [INC_W-1:0] step;
    logic [INC_W-1:0] target;
    logic             ramp_mode;

    dfc_regs #(.INC_W(INC_W), .OFS_W(OFS_W), .CENTRE_DEF(CENTRE_DEF), .STEP_DEF(STEP_DEF)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ctl(ctl), .centre(centre),
        .offs(offs), .step(step)
    );

    dfc_target #(.INC_W(INC_W), .OFS_W(OFS_W)) u_target (
        .ctl(ctl), .locked(mode_locked), .centre(centre), .offs(offs),
        .loop_inc(loop_inc), .target(target), .ramp_mode(ramp_mode)
    );

    dfc_slew #(.INC_W(INC_W), .CENTRE_DEF(CENTRE_DEF)) u_slew (
        .clk(clk), .rst(rst), .halt(ctl.halt), .ramp_mode(ramp_mode), .tick(tick),
        .target(target), .centre(centre), .step(step), .active(active_inc)
    );

    dfc_nco #(.INC_W(INC_W)) u_nco (
        .clk(clk), .rst(rst), .halt(ctl.halt), .inc(active_inc), .clk_en(clk_en)
    );

    assign on_target = (active_inc == target);
    assign cfg_err   = !mode_locked && ctl.fast_req;

    // R4
    locked_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_locked && !ctl.halt) |=> (active_inc == $past(loop_inc)));
endmodule

// File: tb/dpll_freq_ctrl_test.sv
module dpll_freq_ctrl_test;
    localparam int CLK_P = 10;
    localparam logic [31:0] C_DEF = 32'h0100_0000;
    localparam logic [31:0] S_DEF = 32'd16;

    typedef struct packed {
        logic [7:0]  ctl;
        logic [31:0] centre;
        logic [15:0] offs;
        logic        lck;
        logic [31:0] loop;
        logic [31:0] expv;
    } vec_t;

    // R3 R4 R5 R6 vectors; ctl 8'h18 = offset enable + jump
    localparam int NV = 8;
    localparam vec_t VECS [0:NV-1] = '{
        '{8'h00, 32'd1000, 16'd5, 1'b0, 32'd0, 32'd1000},
        '{8'h18, 32'd1000, 16'd5, 1'b0, 32'd0, 32'd1005},
        '{8'h18, 32'd1000, 16'hFFF6, 1'b0, 32'd0, 32'd990},
        '{8'h18, 32'd5, 16'hFF9C, 1'b0, 32'd0, 32'd0},
        '{8'h18, 32'hFFFF_FFF0, 16'd100, 1'b0, 32'd0, 32'hFFFF_FFFF},
        '{8'h18, 32'd1000, 16'd7, 1'b1, 32'd12345, 32'd12345},
        '{8'h00, 32'd1000, 16'd7, 1'b1, 32'd777, 32'd777},
        '{8'h10, 32'd2000, 16'd50, 1'b0, 32'd0, 32'd2000}
    };

    logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, mode_locked = 1'b0, tick = 1'b0;
    logic [1:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0, loop_inc = '0;
    logic [31:0] rd_data, active_inc;
    logic clk_en, on_target, cfg_err;
    int tests = 0, fails = 0;

    always #(CLK_P/2) clk = ~clk;

    dpll_freq_ctrl #(.CENTRE_DEF(C_DEF), .STEP_DEF(S_DEF)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .mode_locked(mode_locked),
        .loop_inc(loop_inc), .tick(tick), .clk_en(clk_en), .active_inc(active_inc),
        .on_target(on_target), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
        tests++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [31:0] expv);
        rd_addr = a;
        #1;
        chk(tag, rd_data, expv);
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int cnt;
        wait_n(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        rd_chk("R1 ctl", 2'd0, 32'd0);
        rd_chk("R1 centre", 2'd1, C_DEF);
        rd_chk("R1 offs", 2'd2, 32'd0);
        rd_chk("R1 step", 2'd3, S_DEF);
        chk("R1 active", active_inc, C_DEF);
        chk("R1 clk_en", {31'd0, clk_en}, 32'd0);

        // R2 read-back encoding
        wr(2'd2, 32'h0000_FFF6);
        rd_chk("R2 offs sign-extended", 2'd2, 32'hFFFF_FFF6);
        wr(2'd0, 32'h0000_01A8);
        rd_chk("R2 ctl 8 bits", 2'd0, 32'h0000_00A8);
        wr(2'd0, 32'd0);

        // table walk: R3 R4 R5 R6 R8
        for (int v = 0; v < NV; v++) begin
            mode_locked = VECS[v].lck;
            loop_inc    = VECS[v].loop;
            wr(2'd0, {24'd0, VECS[v].ctl});
            wr(2'd1, VECS[v].centre);
            wr(2'd2, {16'd0, VECS[v].offs});
            wait_n(3);
            chk($sformatf("R3/R5 table vec %0d active", v), active_inc, VECS[v].expv);
            chk($sformatf("R8 table vec %0d on_target", v), {31'd0, on_target}, 32'd1);
        end
        mode_locked = 1'b0;

        // R7 ramp
        wr(2'd0, 32'h18);
        wr(2'd1, 32'd1000);
        wr(2'd3, 32'd30);
        wr(2'd2, 32'd0);
        wr(2'd0, 32'h08);
        wr(2'd2, 32'd100);
        wait_n(3);
        chk("R7 no tick hold", active_inc, 32'd1000);
        chk("R8 off target", {31'd0, on_target}, 32'd0);
        pulse_tick(); chk("R7 ramp 1", active_inc, 32'd1030);
        pulse_tick(); chk("R7 ramp 2", active_inc, 32'd1060);
        pulse_tick(); chk("R7 ramp 3", active_inc, 32'd1090);
        pulse_tick(); chk("R7 ramp lands", active_inc, 32'd1100);
        chk("R8 reached", {31'd0, on_target}, 32'd1);
        pulse_tick(); chk("R7 stays", active_inc, 32'd1100);
        wr(2'd2, 32'h0000_FFFB);
        pulse_tick(); chk("R7 down 1", active_inc, 32'd1070);
        pulse_tick(); chk("R7 down 2", active_inc, 32'd1040);
        pulse_tick(); chk("R7 down 3", active_inc, 32'd1010);
        pulse_tick(); chk("R7 down lands", active_inc, 32'd995);

        // R9 internal reset
        wr(2'd0, 32'h09);
        wait_n(2);
        chk("R9 held at centre", active_inc, 32'd1000);
        cnt = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (clk_en) cnt++;
        end
        chk("R9 no clk_en", cnt, 0);
        wr(2'd1, 32'd4242);
        rd_chk("R9 centre writable", 2'd1, 32'd4242);
        rd_chk("R9 offs kept", 2'd2, 32'hFFFF_FFFB);
        rd_chk("R9 step kept", 2'd3, 32'd30);
        wait_n(2);
        chk("R9 held new centre", active_inc, 32'd4242);
        wr(2'd0, 32'h00);
        rd_chk("R9 centre after exit", 2'd1, 32'd4242);

        // R10 carry rate
        wr(2'd1, 32'h8000_0000);
        wait_n(4);
        cnt = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (clk_en) cnt++;
        end
        chk("R10 half rate", cnt, 4);
        wr(2'd1, 32'h4000_0000);
        wait_n(4);
        cnt = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (clk_en) cnt++;
        end
        chk("R10 quarter rate", cnt, 4);

        // R11 config error
        wr(2'd0, 32'h20);
        chk("R11 freerun+fast", {31'd0, cfg_err}, 32'd1);
        mode_locked = 1'b1;
        #1;
        chk("R11 locked+fast", {31'd0, cfg_err}, 32'd0);
        mode_locked = 1'b0;
        wr(2'd0, 32'h00);
        chk("R11 freerun only", {31'd0, cfg_err}, 32'd0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule